// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned integers of a parameterised width `W` over several clock cycles. It uses one `W`-bit adder for the whole operation. Four registers hold the state:

- an accumulator,
- a multiplier register,
- a multiplicand register,
- a single carry flip-flop.

The product is built in place across the concatenation of the accumulator and the multiplier register. Each multiplier bit is handled in two phases. In the add phase, the multiplicand is added into the accumulator when the multiplier LSB is 1, and the adder carry-out is caught in the carry flop. In the shift phase, the chain {carry, accumulator, multiplier} moves right by one bit, and the carry flop is cleared.

A client drives both operands together with a one-cycle `start_i` pulse. It then waits for `done_o`, and reads the `2W`-bit product. `busy_o` marks a multiplication in progress. `done_o` stays high, and the product stays frozen, until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `done_o` and `product_o` are all zero. Reset is asynchronous, so this also holds when reset arrives in the middle of an operation.
- R2: `start_i` is accepted at a rising edge when `busy_o` is low, whether the block is idle or done. In the next cycle `busy_o` is 1 and `done_o` is 0.
- R3: `product_o` equals the full `2W`-bit unsigned product of the operands captured at the accepted start. This includes the all-ones by all-ones case, which exercises the carry flop.
- R4: `done_o` rises exactly `2W` rising edges after the accepting edge. `busy_o` is high for exactly those `2W` cycles.
- R5: A `start_i` pulse or an operand change while `busy_o` is high is ignored. Neither the result nor the completion time changes.
- R6: While `done_o` is high and `start_i` is low, `product_o` and `done_o` hold their values.
- R7: A zero operand still takes the full `2W` cycles and yields a product of zero.
- R8: A start accepted while `done_o` is high launches a new multiplication with the new operands.
- R9: `busy_o` and `done_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, sampled while not busy |
| multiplicand_i | input | W | Unsigned multiplicand, captured at accepted start |
| multiplier_i | input | W | Unsigned multiplier, captured at accepted start |
| busy_o | output | 1 | Multiplication in progress |
| done_o | output | 1 | Result valid, held until next accepted start |
| product_o | output | 2W | Unsigned product {accumulator, multiplier register} |

## Verification
The accepting edge counts as cycle zero. `busy_o` is due one cycle later. The product and `done_o` are due `2W` cycles after that edge, and no earlier.

The bench drives inputs on falling edges and samples one half-cycle after each rising edge. After a start it checks that `busy_o` is still high at cycle `2W-1` and that `done_o` is high at cycle `2W`. This pins the latency on both sides.

The hold and ignored-start cases are sampled over several cycles after completion or after the spurious pulse. A checker independently computes the expected product at the accepting edge and counts busy cycles until `done_o` rises.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_e;
endpackage

// File: rtl/shift_add_mul_adder.sv
module shift_add_mul_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W:0] c;
  assign c[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign carry_o = c[W];
endmodule

// File: rtl/shift_add_mul_ctrl.sv
module shift_add_mul_ctrl
  import shift_add_mul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic add_o,
  output logic shift_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  mul_state_e    state_q;
  logic [CW-1:0] step_q;
  logic          phase_q;  // 0: add phase, 1: shift phase
  logic          accept;

  assign accept  = start_i && (state_q != ST_RUN);
  assign load_o  = accept;
  assign add_o   = (state_q == ST_RUN) && !phase_q;
  assign shift_o = (state_q == ST_RUN) && phase_q;
  assign busy_o  = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      phase_q <= 1'b0;
    end else if (accept) begin
      state_q <= ST_RUN;
      step_q  <= '0;
      phase_q <= 1'b0;
    end else if (state_q == ST_RUN) begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        if (step_q == LAST_STEP) state_q <= ST_DONE;
        else                     step_q  <= step_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/shift_add_mul_dp.sv
module shift_add_mul_dp #(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           add_i,
  input  logic           shift_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] product_o
);
  logic [W-1:0] acc_q, mq_q, mcand_q;
  logic         c_q;
  logic [W-1:0] sum;
  logic         cout;

  shift_add_mul_adder #(.W(W)) u_add (
    .a_i    (acc_q),
    .b_i    (mcand_q),
    .sum_o  (sum),
    .carry_o(cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      mq_q    <= '0;
      mcand_q <= '0;
      c_q     <= 1'b0;
    end else if (load_i) begin
      acc_q   <= '0;
      mq_q    <= mplier_i;
      mcand_q <= mcand_i;
      c_q     <= 1'b0;
    end else if (add_i) begin
      if (mq_q[0]) begin
        acc_q <= sum;
        c_q   <= cout;
      end
    end else if (shift_i) begin
      // {C, A, Q} >> 1; carry used once then cleared
      acc_q <= {c_q, acc_q[W-1:1]};
      mq_q  <= {acc_q[0], mq_q[W-1:1]};
      c_q   <= 1'b0;
    end
  end

  assign product_o = {acc_q, mq_q};
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   multiplicand_i,
  input  logic [W-1:0]   multiplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);
  logic load, add, shift;

  shift_add_mul_ctrl #(.W(W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .add_o  (add),
    .shift_o(shift),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  shift_add_mul_dp #(.W(W)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .add_i    (add),
    .shift_i  (shift),
    .mcand_i  (multiplicand_i),
    .mplier_i (multiplier_i),
    .product_o(product_o)
  );
endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
  parameter int W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [W-1:0]   multiplicand_i,
  input logic [W-1:0]   multiplier_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*W-1:0] product_o
);
  logic [2*W-1:0] exp_q;
  int unsigned    cyc_q;
  logic           acc;

  assign acc = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      cyc_q <= 0;
    end else if (acc) begin
      exp_q <= (2*W)'(multiplicand_i) * (2*W)'(multiplier_i);
      cyc_q <= 0;
    end else if (busy_o) begin
      cyc_q <= cyc_q + 1;
    end
  end

  a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (busy_o && !done_o));

  a_r3_product_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (product_o == exp_q));

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (cyc_q == 2*W));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(product_o)));

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

bind shift_add_mul shift_add_mul_chk #(.W(W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .multiplicand_i(multiplicand_i),
  .multiplier_i  (multiplier_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .product_o     (product_o)
);

// File: tb/sim_shift_add_mul.sv
`timescale 1ns/1ps
module sim_shift_add_mul;
  localparam int W  = 8;
  localparam int NV = 8;

  localparam logic [W-1:0]   VA [NV] = '{8'd7, 8'd255, 8'd0,   8'd128, 8'd1,   8'd170, 8'd15,  8'd200};
  localparam logic [W-1:0]   VB [NV] = '{8'd6, 8'd255, 8'd123, 8'd2,   8'd255, 8'd85,  8'd17,  8'd100};
  localparam logic [2*W-1:0] VP [NV] = '{16'd42, 16'd65025, 16'd0, 16'd256, 16'd255, 16'd14450, 16'd255, 16'd20000};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic busy, done;
  logic [2*W-1:0] prod;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  shift_add_mul #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .multiplicand_i(a), .multiplier_i(b),
    .busy_o(busy), .done_o(done), .product_o(prod)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse start on a negedge; return at the negedge after the accepting edge.
  task automatic launch(input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input logic [W-1:0] x, input logic [W-1:0] y,
                     input logic [2*W-1:0] exp, input string req);
    launch(x, y);
    chk(busy && !done, "R2 busy after start", {busy, done}, 2'b10);
    repeat (2*W-1) @(negedge clk);
    chk(busy && !done, "R4 still busy at 2W-1", {busy, done}, 2'b10);
    @(negedge clk);
    chk(done && !busy, "R4 done at 2W", {busy, done}, 2'b01);
    chk(prod == exp, req, prod, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #5;
    chk(!busy && !done && prod == 0, "R1 reset outputs", prod, 0);
    @(negedge clk); rst_n = 1'b1;

    // table walk; each run after the first starts from done (R8)
    for (int i = 0; i < NV; i++) begin
      run(VA[i], VB[i], VP[i], "R3 product vector");
      chk(prod == 2*W'(0) + (2*W)'(VA[i]) * (2*W)'(VB[i]), "R8 restart from done", prod, VP[i]);
    end

    // R7: zero multiplicand and zero multiplier take full time
    run(8'd0, 8'd0, 16'd0, "R7 zero by zero");
    run(8'd99, 8'd0, 16'd0, "R7 zero multiplier");

    // R6: hold while done and no start; operand changes ignored
    a = 8'd3; b = 8'd3;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(done && !busy && prod == 16'd0, "R6 hold after done", prod, 0);
    end

    // R5: start pulse and operand change during busy ignored
    launch(8'd9, 8'd11);
    @(negedge clk);
    a = 8'd255; b = 8'd255; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2*W-3) @(negedge clk);
    chk(busy && !done, "R5 timing unchanged at 2W-1", {busy, done}, 2'b10);
    @(negedge clk);
    chk(done && !busy, "R5 done at 2W", {busy, done}, 2'b01);
    chk(prod == 16'd99, "R5 original operands", prod, 99);
    chk(!(busy && done), "R9 exclusive", {busy, done}, 2'b01);

    // R1: asynchronous reset mid-operation
    launch(8'd200, 8'd200);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk(!busy && !done && prod == 0, "R1 async reset mid-run", prod, 0);
    @(negedge clk); rst_n = 1'b1;
    run(8'd13, 8'd11, 16'd143, "R3 after reset");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule